// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a word-wide main-memory port. Each 16-bit word address is split into three fields: a tag, a line index and a word offset. The index picks the single line the address may occupy. A stored tag and a valid bit decide whether the access hits. Hits finish in the cycle they are presented and never touch memory. A miss allocates the line: the whole 16-word block is fetched, for reads and writes alike.

Writes stay in the cache and mark the line as modified. Main memory is only brought up to date when a modified line is displaced. At that point the complete line goes back to memory, word 0 first, and the fetch of the new block starts only after that. On a read miss the processor does not wait for the whole line. The requested word is handed over in the very cycle memory delivers it, while the rest of the line keeps streaming in.

The processor holds its request until `cpu_ready` is high. Memory transfers use a request/acknowledge pair. A transfer happens in a cycle in which both `mem_req` and `mem_ack` are high, and read data is valid in that same cycle.

Top module: `dmc_cache`

## Requirements
- R1: The address splits as follows: bits [3:0] are the word offset, bits [10:4] are the line index and bits [15:11] are the tag. Memory block j may live only in line j mod 128, and a new block displaces whatever that line holds.
- R2: A read that hits returns the cached word with `cpu_ready` high in the same cycle, and no memory transfer takes place.
- R3: A write that hits is accepted with `cpu_ready` high in the same cycle. It updates only the cache and marks the line modified, with no memory transfer.
- R4: A miss that displaces a modified line first writes back all 16 words of that line (`mem_we`=1), offsets 0 to 15 in order, with the cached contents. This happens before any fetch read.
- R5: A write miss fetches the whole block. In the cycle after the last fetch acknowledge, the still-held write hits and overwrites the addressed word, which leaves the line modified.
- R6: On a read miss, `cpu_ready` is high for exactly one cycle: the cycle in which memory acknowledges the requested word. In that cycle `cpu_rdata` equals the memory word.
- R7: While a miss is being serviced, `cpu_ready` is low in every cycle other than the one named in R6.
- R8: Reset clears every valid and modified flag. The first access to any line after reset therefore misses and causes no write-back.
- R9: A fetch reads offsets 0 to 15 in order with `mem_we`=0 and stores every acknowledged word. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid when ready on a read |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = fetch |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write-back data |
| mem_rdata | input | 16 | Fetch data, valid with mem_ack |
| mem_ack | input | 1 | Transfer accepted this cycle |

## Verification
The bench forces conflicts on one line by reusing an index with a different tag. A design that did not write back, or wrote back stale data, would return old values when that address is read again later. It places the requested word at offset 0, in the middle of the line and at offset 15, and issues the next access right after the early word arrives. A design that pulsed ready at the wrong beat, or acted on a request presented during the fetch, would be flagged cycle by cycle. Write misses are checked by reading the word back and then evicting the line. An implementation that wrote without allocating, or forgot to mark the line modified, would lose the store. Memory latency varies between zero and two cycles to expose address changes made before the acknowledge.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
// Shared types for the direct-mapped cache: controller state encoding.
package dmc_pkg;
    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_EVICT = 2'd1,
        CS_FILL  = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/dmc_tag_store.sv
`timescale 1ns/1ps
// Per-line tag, valid and modified flags with combinational lookup.
// Assumes install and mark never target a line in the same cycle.
module dmc_tag_store #(
    parameter int IDX_W = 7,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_dirty,
    output logic [TAG_W-1:0] lk_vtag,
    input  logic             mark_dirty,
    input  logic [IDX_W-1:0] mark_idx,
    input  logic             install,
    input  logic [IDX_W-1:0] inst_idx,
    input  logic [TAG_W-1:0] inst_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Flag update: reset clears all, install validates clean, store marks modified.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (install) begin
                valid_q[inst_idx] <= 1'b1;
                dirty_q[inst_idx] <= 1'b0;
            end
            if (mark_dirty) begin
                dirty_q[mark_idx] <= 1'b1;
            end
        end
    end

    // Tag write on install; tags need no reset as valid gates them.
    always_ff @(posedge clk) begin
        if (install) begin
            tag_q[inst_idx] <= inst_tag;
        end
    end

    // Lookup of the presented index.
    always_comb begin
        lk_vtag  = tag_q[lk_idx];
        lk_hit   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_dirty = valid_q[lk_idx] && dirty_q[lk_idx];
    end
endmodule

// File: rtl/dmc_data_store.sv
`timescale 1ns/1ps
// Line data array: one write port, two combinational read ports
// (processor side and write-back side). Contents are not reset.
module dmc_data_store #(
    parameter int AW     = 11,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     ra_a,
    output logic [DATA_W-1:0] rd_a,
    input  logic [AW-1:0]     ra_b,
    output logic [DATA_W-1:0] rd_b
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Single write port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Asynchronous reads for same-cycle hits and write-back data.
    assign rd_a = mem_q[ra_a];
    assign rd_b = mem_q[ra_b];
endmodule

// File: rtl/dmc_ctrl.sv
`timescale 1ns/1ps
// Miss sequencer: latches the missing address, writes back a modified
// victim word by word, then fetches the new block word by word.
// Assumes memory holds a transfer until acknowledged.
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int OFF_W = 4,
    parameter int TAG_W = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [TAG_W-1:0]             req_tag,
    input  logic [IDX_W-1:0]             req_idx,
    input  logic [OFF_W-1:0]             req_off,
    input  logic                         lk_hit,
    input  logic                         lk_dirty,
    input  logic [TAG_W-1:0]             lk_vtag,
    input  logic                         mem_ack,
    output logic                         is_idle,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [TAG_W+IDX_W+OFF_W-1:0] mem_addr,
    output logic [IDX_W-1:0]             line_idx,
    output logic [OFF_W-1:0]             word_cnt,
    output logic [TAG_W-1:0]             line_tag,
    output logic                         fill_wr,
    output logic                         fill_last,
    output logic                         early_hit
);
    localparam logic [OFF_W-1:0] LAST = '1;

    ctl_state_t       state_q;
    logic [OFF_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [TAG_W-1:0] tag_q;
    logic [TAG_W-1:0] vtag_q;
    logic [OFF_W-1:0] off_q;
    logic             rd_q;

    // State, beat counter and latched miss context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            tag_q   <= '0;
            vtag_q  <= '0;
            off_q   <= '0;
            rd_q    <= 1'b0;
        end else begin
            case (state_q)
                CS_IDLE: begin
                    if (cpu_req && !lk_hit) begin
                        idx_q   <= req_idx;
                        tag_q   <= req_tag;
                        vtag_q  <= lk_vtag;
                        off_q   <= req_off;
                        rd_q    <= !cpu_we;
                        cnt_q   <= '0;
                        state_q <= lk_dirty ? CS_EVICT : CS_FILL;
                    end
                end
                CS_EVICT: begin
                    if (mem_ack) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST) begin
                            state_q <= CS_FILL;
                        end
                    end
                end
                CS_FILL: begin
                    if (mem_ack) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST) begin
                            state_q <= CS_IDLE;
                        end
                    end
                end
                default: state_q <= CS_IDLE;
            endcase
        end
    end

    // Memory-side request and per-beat strobes.
    always_comb begin
        is_idle   = (state_q == CS_IDLE);
        mem_req   = (state_q != CS_IDLE);
        mem_we    = (state_q == CS_EVICT);
        mem_addr  = {(state_q == CS_EVICT) ? vtag_q : tag_q, idx_q, cnt_q};
        line_idx  = idx_q;
        word_cnt  = cnt_q;
        line_tag  = tag_q;
        fill_wr   = (state_q == CS_FILL) && mem_ack;
        fill_last = fill_wr && (cnt_q == LAST);
        early_hit = fill_wr && rd_q && (cnt_q == off_q);
    end
endmodule

// File: rtl/dmc_cache.sv
`timescale 1ns/1ps
// Direct-mapped write-back data cache, allocate on every miss, early
// restart on read misses. Processor holds requests until cpu_ready.
module dmc_cache #(
    parameter int TAG_W  = 5,
    parameter int IDX_W  = 7,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [TAG_W+IDX_W+OFF_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0]            cpu_wdata,
    output logic [DATA_W-1:0]            cpu_rdata,
    output logic                         cpu_ready,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [TAG_W+IDX_W+OFF_W-1:0] mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    input  logic [DATA_W-1:0]            mem_rdata,
    input  logic                         mem_ack
);
    localparam int DAW = IDX_W + OFF_W;

    logic [OFF_W-1:0]  req_off;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic              lk_hit, lk_dirty;
    logic [TAG_W-1:0]  lk_vtag;
    logic              is_idle, fill_wr, fill_last, early_hit;
    logic [IDX_W-1:0]  line_idx;
    logic [OFF_W-1:0]  word_cnt;
    logic [TAG_W-1:0]  line_tag;
    logic              wr_hit, hit_ready, ds_we;
    logic [DAW-1:0]    ds_waddr;
    logic [DATA_W-1:0] ds_wdata, rd_cpu;

    // Address field split.
    assign req_off = cpu_addr[OFF_W-1:0];
    assign req_idx = cpu_addr[OFF_W +: IDX_W];
    assign req_tag = cpu_addr[OFF_W+IDX_W +: TAG_W];

    dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(req_idx), .lk_tag(req_tag),
        .lk_hit(lk_hit), .lk_dirty(lk_dirty), .lk_vtag(lk_vtag),
        .mark_dirty(wr_hit), .mark_idx(req_idx),
        .install(fill_last), .inst_idx(line_idx), .inst_tag(line_tag)
    );

    dmc_ctrl #(.IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we),
        .req_tag(req_tag), .req_idx(req_idx), .req_off(req_off),
        .lk_hit(lk_hit), .lk_dirty(lk_dirty), .lk_vtag(lk_vtag),
        .mem_ack(mem_ack), .is_idle(is_idle),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .line_idx(line_idx), .word_cnt(word_cnt), .line_tag(line_tag),
        .fill_wr(fill_wr), .fill_last(fill_last), .early_hit(early_hit)
    );

    // Hit qualification: lookups count only while no miss is in progress.
    always_comb begin
        hit_ready = is_idle && cpu_req && lk_hit;
        wr_hit    = hit_ready && cpu_we;
    end

    // Data array write select: fetched word takes the port during a fill.
    always_comb begin
        ds_we    = wr_hit || fill_wr;
        ds_waddr = fill_wr ? {line_idx, word_cnt} : {req_idx, req_off};
        ds_wdata = fill_wr ? mem_rdata : cpu_wdata;
    end

    dmc_data_store #(.AW(DAW), .DATA_W(DATA_W)) u_data (
        .clk(clk), .we(ds_we), .waddr(ds_waddr), .wdata(ds_wdata),
        .ra_a({req_idx, req_off}), .rd_a(rd_cpu),
        .ra_b({line_idx, word_cnt}), .rd_b(mem_wdata)
    );

    // Processor response: same-cycle hit or forwarded fetch word.
    always_comb begin
        cpu_ready = hit_ready || early_hit;
        cpu_rdata = early_hit ? mem_rdata : rd_cpu;
    end
endmodule

// File: rtl/dmc_cache_chk.sv
`timescale 1ns/1ps
// Port-level protocol checks for dmc_cache, attached by bind.
module dmc_cache_chk #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_we,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);
    // R7
    evict_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !cpu_ready);
    // R6
    early_on_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && mem_req) |-> (!mem_we && mem_ack));
    // R3
    write_hit_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we) |-> !mem_req);
    // R9
    fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && (mem_addr[OFF_W-1:0] != '1)) |=>
        (mem_req && !mem_we && (mem_addr[OFF_W-1:0] == $past(mem_addr[OFF_W-1:0]) + 1'b1)));
    // R4
    evict_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && (mem_addr[OFF_W-1:0] == '1)) |=>
        (mem_req && !mem_we && (mem_addr[OFF_W-1:0] == '0)));
    // R9
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R8
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !mem_req);
endmodule

bind dmc_cache dmc_cache_chk #(.ADDR_W(TAG_W+IDX_W+OFF_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/sim_dmc_cache.sv
`timescale 1ns/1ps
module sim_dmc_cache;
    localparam int LINES = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    dmc_cache u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    typedef struct {
        bit          we;
        logic [15:0] addr;
        logic [15:0] data;
        bit          early;
    } xfer_t;

    xfer_t       expq[$];
    logic [15:0] golden[int];
    logic [15:0] memm[int];
    bit          mv[LINES];
    logic [4:0]  mt[LINES];
    bit          md[LINES];
    bit          wmiss_pend = 0;

    function automatic logic [15:0] init_val(logic [15:0] a);
        return 16'(a * 16'h03B1) ^ 16'h5A5A;
    endfunction
    function automatic logic [15:0] gval(logic [15:0] a);
        return golden.exists(int'(a)) ? golden[int'(a)] : init_val(a);
    endfunction
    function automatic logic [15:0] mval(logic [15:0] a);
        return memm.exists(int'(a)) ? memm[int'(a)] : init_val(a);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Memory model: latency 0..2 cycles, responds after each falling edge.
    int lat = 0, wcnt = 0;
    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ack   = 1'b1;
                mem_rdata = mval(mem_addr);
                wcnt      = 0;
                lat       = (lat + 1) % 3;
            end else begin
                mem_ack = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ack = 1'b0;
        end
    end
    always @(posedge clk) begin
        if (mem_req && mem_ack && mem_we) memm[int'(mem_addr)] = mem_wdata;
    end

    // Reference model, evaluated each cycle shortly before the rising edge.
    task automatic step();
        xfer_t e;
        int idx;
        logic [4:0] tg;
        logic [15:0] a, wa;
        if (expq.size() > 0) begin
            if (mem_req && mem_ack) begin
                e = expq.pop_front();
                if (e.we) begin
                    chk(mem_we == 1'b1, "R4", "write-back direction", 32'(mem_we), 1);
                    chk(mem_addr == e.addr, "R4", "write-back address", 32'(mem_addr), 32'(e.addr));
                    chk(mem_wdata == e.data, "R4", "write-back data", 32'(mem_wdata), 32'(e.data));
                end else begin
                    chk(mem_we == 1'b0, "R9", "fetch direction", 32'(mem_we), 0);
                    chk(mem_addr == e.addr, "R1", "fetch address", 32'(mem_addr), 32'(e.addr));
                end
                if (e.early) begin
                    chk(cpu_ready == 1'b1, "R6", "early ready", 32'(cpu_ready), 1);
                    chk(cpu_rdata == e.data, "R6", "early data", 32'(cpu_rdata), 32'(e.data));
                end else begin
                    chk(cpu_ready == 1'b0, "R7", "ready on non-requested beat", 32'(cpu_ready), 0);
                end
            end else begin
                chk(cpu_ready == 1'b0, "R7", "ready while waiting on memory", 32'(cpu_ready), 0);
            end
        end else begin
            if (mem_req && mem_ack)
                chk(1'b0, "R2", "memory transfer with no miss", 32'(mem_addr), 0);
            if (cpu_req) begin
                a   = cpu_addr;
                idx = int'(a[10:4]);
                tg  = a[15:11];
                if (mv[idx] && mt[idx] == tg) begin
                    if (cpu_we) begin
                        chk(cpu_ready == 1'b1, wmiss_pend ? "R5" : "R3", "write accepted", 32'(cpu_ready), 1);
                        golden[int'(a)] = cpu_wdata;
                        md[idx] = 1;
                        wmiss_pend = 0;
                    end else begin
                        chk(cpu_ready == 1'b1, "R2", "read hit ready", 32'(cpu_ready), 1);
                        chk(cpu_rdata == gval(a), "R2", "read hit data", 32'(cpu_rdata), 32'(gval(a)));
                    end
                end else begin
                    chk(cpu_ready == 1'b0, mv[idx] ? "R1" : "R8", "ready on miss", 32'(cpu_ready), 0);
                    if (mv[idx] && md[idx]) begin
                        for (int w = 0; w < 16; w++) begin
                            wa = {mt[idx], 7'(idx), 4'(w)};
                            expq.push_back('{1'b1, wa, gval(wa), 1'b0});
                        end
                    end
                    for (int w = 0; w < 16; w++) begin
                        wa = {tg, 7'(idx), 4'(w)};
                        expq.push_back('{1'b0, wa, gval(wa), (!cpu_we) && (4'(w) == a[3:0])});
                    end
                    mv[idx] = 1; mt[idx] = tg; md[idx] = 0;
                    wmiss_pend = cpu_we;
                end
            end else begin
                chk(cpu_ready == 1'b0, "R2", "ready with no request", 32'(cpu_ready), 0);
            end
        end
    endtask

    always begin
        @(negedge clk);
        #5;
        if (rst_n && !done) step();
    end

    task automatic access(input bit we, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        forever begin
            #5;
            if (cpu_ready) break;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        cpu_req = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        #4000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    int unsigned seed = 32'h1234_5678;
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R8: reset state at the ports
        chk(cpu_ready == 1'b0, "R8", "ready after reset", 32'(cpu_ready), 0);
        chk(mem_req == 1'b0, "R8", "memory idle after reset", 32'(mem_req), 0);

        access(0, 16'h0000, 0);       // R8 cold miss, early at offset 0
        access(0, 16'h0005, 0);       // R2 hit
        access(0, 16'h000F, 0);
        access(0, 16'h0127, 0);       // R6 early mid-line
        access(1, 16'h0123, 16'hBEEF);// R3 write hit
        access(0, 16'h0123, 0);
        access(0, 16'h0923, 0);       // R1 same line, new tag: R4 write-back
        access(0, 16'h0123, 0);       // R4 data came back from memory
        access(1, 16'h1A5F, 16'hC0DE);// R5 write miss
        access(0, 16'h1A5F, 0);
        access(0, 16'h025F, 0);       // evicts modified line, early at offset 15
        access(0, 16'h1A5F, 0);
        idle(4);
        for (int i = 0; i < 220; i++) begin
            logic [15:0] a;
            seed = seed * 32'd1103515245 + 32'd12345;
            a = {3'b000, seed[17:16], 5'b0, seed[19:18], seed[23:20]};
            access(seed[24], a, seed[31:16]);
            if (seed[27:25] == 3'd0) idle(2);
        end
        idle(40);
        chk(expq.size() == 0, "R9", "all expected transfers seen", 32'(expq.size()), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule